// File: doc/BRIEF.md
# Sliding-Window General Register File

This block is a general-purpose register file of 32-bit registers. Instructions see it only through a window of 16 logical registers, so every operand field is 4 bits wide. A window base, counted in groups of four physical registers, maps each logical number onto a physical entry. The mapping wraps modulo the physical register count, which is 32 or 64 and set by a parameter.

On a call, a rotate command slides the window forward by 4, 8 or 12 registers. The called code then finds fresh registers and does not need to save the caller's values. A restore command on return slides the window back by the amount of the matching rotate. The amounts of open frames are held in a small last-in, first-out history.

A rotate that would run the new window into the registers of an older live frame raises a one-cycle overflow flag. So does a rotate when the history is full. A restore with no history raises a one-cycle underflow flag. A flagged command changes no state; spilling and recovery are left to the surrounding logic.

Top module: `winreg_file`

## Requirements
- R1: A synchronous reset (`rst` high at a clock edge) sets every register to zero, the window base to zero and the history to empty, and leaves both flags low in the following cycle.
- R2: Each of the two read ports returns, combinationally, physical register ((base*4 + logical index) mod PHYS_REGS). The two ports are independent of each other.
- R3: A write stores `wr_data` in the physical register that the current base maps `wr_lidx` onto. A read of that register in the same cycle returns the value from before the write.
- R4: A rotate with `rot_amt` encoded 1, 2 or 3 advances the base by 1, 2 or 3 groups (4, 8 or 12 registers). Registers outside the new window keep their values, so the caller's logical register 4*k appears as logical 0 after a rotate by 4*k. Code 0 leaves all state unchanged and raises no flag.
- R5: A restore moves the base back by the amount of the most recent unmatched rotate, in last-in, first-out order.
- R6: A rotate raises `ovf_flag` for the one following cycle and changes no state in either of two cases: the history already holds HIST_DEPTH frames, or (sum of held amounts + requested amount + 4) exceeds PHYS_REGS/4 groups.
- R7: A restore with an empty history raises `unf_flag` for the one following cycle and changes no state.
- R8: When a rotate and a write occur in the same cycle, the write uses the base from before the rotate.
- R9: When `rot_en` and `ret_en` are both high, the rotate command is carried out and the restore is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| rd0_lidx | input | 4 | Logical index, read port 0 |
| rd0_data | output | 32 | Read data, port 0 |
| rd1_lidx | input | 4 | Logical index, read port 1 |
| rd1_data | output | 32 | Read data, port 1 |
| wr_en | input | 1 | Write enable |
| wr_lidx | input | 4 | Logical index for the write |
| wr_data | input | 32 | Write data |
| rot_en | input | 1 | Rotate the window forward (call) |
| rot_amt | input | 2 | Rotate amount in groups of four: 0 none, 1, 2, 3 |
| ret_en | input | 1 | Restore the previous window (return) |
| ovf_flag | output | 1 | Window overflow, one cycle after the refused rotate |
| unf_flag | output | 1 | Window underflow, one cycle after the refused restore |

## Verification
The properties assume that `rot_amt` is a settled 2-bit value whenever `rot_en` is high. They also assume that the command inputs are not relied on in a reset cycle, because reset overrides everything. The bench drives every input at the falling edge, so each command is stable across the rising edge. The random stimulus mixes rotates of all four codes with restores, including cycles that assert both. Directed runs push the history to its depth limit and to its group limit, and pull it below empty, so that both flag conditions and the priority rule are reached.

// File: rtl/wrf_pkg.sv
`timescale 1ns/1ps
package wrf_pkg;
   localparam int unsigned LOG_REGS  = 16;
   localparam int unsigned LOG_W     = 4;
   localparam int unsigned GROUP_SZ  = 4;
   localparam int unsigned WIN_GRPS  = LOG_REGS / GROUP_SZ;

   typedef enum logic [1:0] {
      ROT_NONE = 2'd0,
      ROT_4    = 2'd1,
      ROT_8    = 2'd2,
      ROT_12   = 2'd3
   } rot_amt_e;
endpackage

// File: rtl/wrf_index_map.sv
`timescale 1ns/1ps
module wrf_index_map #(
   parameter int unsigned PHYS_REGS = 64,
   localparam int unsigned PHYS_W   = $clog2(PHYS_REGS),
   localparam int unsigned BASE_W   = PHYS_W - 2
) (
   input  logic [BASE_W-1:0]          base,
   input  logic [wrf_pkg::LOG_W-1:0]  lidx,
   output logic [PHYS_W-1:0]          pidx
);
   // wraps modulo PHYS_REGS because PHYS_REGS is a power of two
   always_comb begin
      pidx = {base, 2'b00} + PHYS_W'(lidx);
   end
endmodule

// File: rtl/wrf_storage.sv
`timescale 1ns/1ps
module wrf_storage #(
   parameter int unsigned DATA_W    = 32,
   parameter int unsigned PHYS_REGS = 64,
   parameter int unsigned RD_PORTS  = 2,
   localparam int unsigned PHYS_W   = $clog2(PHYS_REGS)
) (
   input  logic                              clk,
   input  logic                              rst,
   input  logic                              wr_en,
   input  logic [PHYS_W-1:0]                 wr_pidx,
   input  logic [DATA_W-1:0]                 wr_data,
   input  logic [RD_PORTS-1:0][PHYS_W-1:0]   rd_pidx,
   output logic [RD_PORTS-1:0][DATA_W-1:0]   rd_data
);
   logic [DATA_W-1:0] regs_q [PHYS_REGS];

   always_ff @(posedge clk) begin
      if (rst) begin
         for (int i = 0; i < PHYS_REGS; i++) regs_q[i] <= '0;
      end else if (wr_en) begin
         regs_q[wr_pidx] <= wr_data;
      end
   end

   for (genvar p = 0; p < RD_PORTS; p++) begin : g_rd
      assign rd_data[p] = regs_q[rd_pidx[p]];
   end
endmodule

// File: rtl/wrf_window_ctrl.sv
`timescale 1ns/1ps
module wrf_window_ctrl #(
   parameter int unsigned GROUPS     = 16,
   parameter int unsigned HIST_DEPTH = 8,
   localparam int unsigned BASE_W    = $clog2(GROUPS),
   localparam int unsigned CNT_W     = $clog2(HIST_DEPTH + 1),
   localparam int unsigned PTR_W     = $clog2(HIST_DEPTH),
   localparam int unsigned SUM_W     = $clog2(HIST_DEPTH * 3 + GROUPS + 8)
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              rot_en,
   input  logic [1:0]        rot_amt,
   input  logic              ret_en,
   output logic [BASE_W-1:0] base,
   output logic [CNT_W-1:0]  hist_cnt,
   output logic              ovf_flag,
   output logic              unf_flag
);
   import wrf_pkg::*;

   logic [1:0]       stk_q [HIST_DEPTH];
   logic [BASE_W-1:0] base_q;
   logic [CNT_W-1:0]  cnt_q;
   logic [SUM_W-1:0]  sum_q;
   logic              ovf_q, unf_q;

   logic              rot_req, ret_req, hist_full, hist_empty;
   logic              ovf_cond, unf_cond;
   logic [SUM_W-1:0]  need_grps;
   logic [PTR_W-1:0]  push_ptr, top_ptr;
   logic [1:0]        top_amt;

   always_comb begin
      rot_req    = rot_en && (rot_amt_e'(rot_amt) != ROT_NONE);
      ret_req    = ret_en && !rot_en;
      hist_full  = (cnt_q == CNT_W'(HIST_DEPTH));
      hist_empty = (cnt_q == '0);
      need_grps  = sum_q + SUM_W'(rot_amt) + SUM_W'(WIN_GRPS);
      ovf_cond   = rot_req && (hist_full || (need_grps > SUM_W'(GROUPS)));
      unf_cond   = ret_req && hist_empty;
      push_ptr   = PTR_W'(cnt_q);
      top_ptr    = PTR_W'(cnt_q - CNT_W'(1));
      top_amt    = stk_q[top_ptr];
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         base_q <= '0;
         cnt_q  <= '0;
         sum_q  <= '0;
         ovf_q  <= 1'b0;
         unf_q  <= 1'b0;
         for (int i = 0; i < HIST_DEPTH; i++) stk_q[i] <= '0;
      end else begin
         ovf_q <= ovf_cond;
         unf_q <= unf_cond;
         if (rot_req && !ovf_cond) begin
            stk_q[push_ptr] <= rot_amt;
            cnt_q           <= cnt_q + CNT_W'(1);
            sum_q           <= sum_q + SUM_W'(rot_amt);
            base_q          <= base_q + BASE_W'(rot_amt);
         end else if (ret_req && !unf_cond) begin
            cnt_q  <= cnt_q - CNT_W'(1);
            sum_q  <= sum_q - SUM_W'(top_amt);
            base_q <= base_q - BASE_W'(top_amt);
         end
      end
   end

   assign base     = base_q;
   assign hist_cnt = cnt_q;
   assign ovf_flag = ovf_q;
   assign unf_flag = unf_q;
endmodule

// File: rtl/winreg_file.sv
`timescale 1ns/1ps
module winreg_file #(
   parameter int unsigned DATA_W     = 32,
   parameter int unsigned PHYS_REGS  = 64,
   parameter int unsigned HIST_DEPTH = 8
) (
   input  logic              clk,
   input  logic              rst,
   input  logic [3:0]        rd0_lidx,
   output logic [DATA_W-1:0] rd0_data,
   input  logic [3:0]        rd1_lidx,
   output logic [DATA_W-1:0] rd1_data,
   input  logic              wr_en,
   input  logic [3:0]        wr_lidx,
   input  logic [DATA_W-1:0] wr_data,
   input  logic              rot_en,
   input  logic [1:0]        rot_amt,
   input  logic              ret_en,
   output logic              ovf_flag,
   output logic              unf_flag
);
   localparam int unsigned PHYS_W = $clog2(PHYS_REGS);
   localparam int unsigned GROUPS = PHYS_REGS / wrf_pkg::GROUP_SZ;
   localparam int unsigned BASE_W = $clog2(GROUPS);
   localparam int unsigned CNT_W  = $clog2(HIST_DEPTH + 1);
   localparam int unsigned N_MAP  = 3;  // two read ports, one write port

   if (PHYS_REGS != 32 && PHYS_REGS != 64) begin : g_bad_phys
      $error("PHYS_REGS must be 32 or 64");
   end
   if (HIST_DEPTH < 2 || (HIST_DEPTH & (HIST_DEPTH - 1)) != 0) begin : g_bad_depth
      $error("HIST_DEPTH must be a power of two, at least 2");
   end
   if (DATA_W < 1) begin : g_bad_width
      $error("DATA_W must be positive");
   end

   logic [BASE_W-1:0]             win_base;
   logic [CNT_W-1:0]              hist_cnt;
   logic [N_MAP-1:0][3:0]         map_lidx;
   logic [N_MAP-1:0][PHYS_W-1:0]  map_pidx;
   logic [1:0][PHYS_W-1:0]        rd_pidx;
   logic [1:0][DATA_W-1:0]        rd_data;

   assign map_lidx[0] = rd0_lidx;
   assign map_lidx[1] = rd1_lidx;
   assign map_lidx[2] = wr_lidx;

   for (genvar m = 0; m < N_MAP; m++) begin : g_map
      wrf_index_map #(.PHYS_REGS(PHYS_REGS)) u_map (
         .base (win_base),
         .lidx (map_lidx[m]),
         .pidx (map_pidx[m])
      );
   end

   assign rd_pidx[0] = map_pidx[0];
   assign rd_pidx[1] = map_pidx[1];

   wrf_window_ctrl #(.GROUPS(GROUPS), .HIST_DEPTH(HIST_DEPTH)) u_ctrl (
      .clk      (clk),
      .rst      (rst),
      .rot_en   (rot_en),
      .rot_amt  (rot_amt),
      .ret_en   (ret_en),
      .base     (win_base),
      .hist_cnt (hist_cnt),
      .ovf_flag (ovf_flag),
      .unf_flag (unf_flag)
   );

   wrf_storage #(.DATA_W(DATA_W), .PHYS_REGS(PHYS_REGS), .RD_PORTS(2)) u_store (
      .clk     (clk),
      .rst     (rst),
      .wr_en   (wr_en),
      .wr_pidx (map_pidx[2]),
      .wr_data (wr_data),
      .rd_pidx (rd_pidx),
      .rd_data (rd_data)
   );

   assign rd0_data = rd_data[0];
   assign rd1_data = rd_data[1];
endmodule

// File: rtl/winreg_file_chk.sv
`timescale 1ns/1ps
module winreg_file_chk #(
   parameter int unsigned BASE_W = 4,
   parameter int unsigned CNT_W  = 4
) (
   input logic              clk,
   input logic              rst,
   input logic              rot_en,
   input logic [1:0]        rot_amt,
   input logic              ret_en,
   input logic              ovf_flag,
   input logic              unf_flag,
   input logic [BASE_W-1:0] base,
   input logic [CNT_W-1:0]  hist_cnt
);
   // R1
   reset_state_chk: assert property (@(posedge clk)
      rst |=> (base == '0 && hist_cnt == '0 && !ovf_flag && !unf_flag));

   // R4
   rotate_step_chk: assert property (@(posedge clk) disable iff (rst)
      (rot_en && rot_amt != 2'd0) |=>
         (ovf_flag || base == $past(base) + BASE_W'($past(rot_amt))));

   // R4
   rotate_zero_chk: assert property (@(posedge clk) disable iff (rst)
      (rot_en && rot_amt == 2'd0) |=>
         ($stable(base) && $stable(hist_cnt) && !ovf_flag && !unf_flag));

   // R5
   restore_pop_chk: assert property (@(posedge clk) disable iff (rst)
      (ret_en && !rot_en) |=> (unf_flag || hist_cnt == $past(hist_cnt) - CNT_W'(1)));

   // R6
   overflow_hold_chk: assert property (@(posedge clk) disable iff (rst)
      ovf_flag |-> (base == $past(base) && hist_cnt == $past(hist_cnt)));

   // R7
   underflow_hold_chk: assert property (@(posedge clk) disable iff (rst)
      unf_flag |-> (base == $past(base) && $past(hist_cnt) == '0));

   // R9
   rotate_wins_chk: assert property (@(posedge clk) disable iff (rst)
      (rot_en && ret_en) |=> !unf_flag);

   // R6
   flag_excl_chk: assert property (@(posedge clk) disable iff (rst)
      !(ovf_flag && unf_flag));
endmodule

bind winreg_file winreg_file_chk #(.BASE_W(BASE_W), .CNT_W(CNT_W)) u_chk (
   .clk      (clk),
   .rst      (rst),
   .rot_en   (rot_en),
   .rot_amt  (rot_amt),
   .ret_en   (ret_en),
   .ovf_flag (ovf_flag),
   .unf_flag (unf_flag),
   .base     (win_base),
   .hist_cnt (hist_cnt)
);

// File: tb/winreg_file_test.sv
`timescale 1ns/1ps
module winreg_file_test;
   localparam int PHYS = 64;
   localparam int DEPTH = 8;
   localparam int GRPS = PHYS / 4;

   logic        clk = 1'b0;
   logic        rst = 1'b1;
   logic [3:0]  rd0_lidx = '0, rd1_lidx = '0, wr_lidx = '0;
   logic [31:0] rd0_data, rd1_data, wr_data = '0;
   logic        wr_en = 1'b0, rot_en = 1'b0, ret_en = 1'b0;
   logic [1:0]  rot_amt = '0;
   logic        ovf_flag, unf_flag;

   int errors = 0;
   int checks = 0;
   bit done = 1'b0;

   logic [31:0] m_mem [PHYS];
   int m_base, m_cnt, m_sum;
   int m_stk [DEPTH];
   bit e_ovf, e_unf;

   always #2 clk = ~clk;

   winreg_file #(.DATA_W(32), .PHYS_REGS(PHYS), .HIST_DEPTH(DEPTH)) uut (
      .clk(clk), .rst(rst),
      .rd0_lidx(rd0_lidx), .rd0_data(rd0_data),
      .rd1_lidx(rd1_lidx), .rd1_data(rd1_data),
      .wr_en(wr_en), .wr_lidx(wr_lidx), .wr_data(wr_data),
      .rot_en(rot_en), .rot_amt(rot_amt), .ret_en(ret_en),
      .ovf_flag(ovf_flag), .unf_flag(unf_flag)
   );

   function automatic int phys(int b, int l);
      return (b * 4 + l) % PHYS;
   endfunction

   task automatic check(string tag, string what, logic [31:0] act, logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s %s: actual=%h expected=%h", tag, what, act, exp);
      end
   endtask

   task automatic model_reset();
      for (int i = 0; i < PHYS; i++) m_mem[i] = '0;
      for (int i = 0; i < DEPTH; i++) m_stk[i] = 0;
      m_base = 0; m_cnt = 0; m_sum = 0; e_ovf = 0; e_unf = 0;
   endtask

   // one clock: drive at falling edge, check reads, then flags after the rising edge
   task automatic step(string tag, bit we, int wi, logic [31:0] wd,
                       bit re, int ra, bit rt, int a0, int a1);
      @(negedge clk);
      wr_en = we; wr_lidx = 4'(wi); wr_data = wd;
      rot_en = re; rot_amt = 2'(ra); ret_en = rt;
      rd0_lidx = 4'(a0); rd1_lidx = 4'(a1);
      #1;
      check(tag, "rd0", rd0_data, m_mem[phys(m_base, a0)]);
      check(tag, "rd1", rd1_data, m_mem[phys(m_base, a1)]);
      @(posedge clk);
      e_ovf = 0; e_unf = 0;
      if (we) m_mem[phys(m_base, wi)] = wd;
      if (re && ra != 0) begin
         if (m_cnt == DEPTH || m_sum + ra + 4 > GRPS) e_ovf = 1;
         else begin
            m_stk[m_cnt] = ra; m_cnt++; m_sum += ra;
            m_base = (m_base + ra) % GRPS;
         end
      end else if (rt && !re) begin
         if (m_cnt == 0) e_unf = 1;
         else begin
            m_cnt--; m_sum -= m_stk[m_cnt];
            m_base = (m_base + GRPS - m_stk[m_cnt]) % GRPS;
         end
      end
      #1;
      check(tag, "ovf_flag", 32'(ovf_flag), 32'(e_ovf));
      check(tag, "unf_flag", 32'(unf_flag), 32'(e_unf));
      wr_en = 0; rot_en = 0; ret_en = 0;
   endtask

   task automatic idle_read(string tag, int a0, int a1);
      step(tag, 0, 0, '0, 0, 0, 0, a0, a1);
   endtask

   initial begin
      #800000;
      if (!done) begin
         errors++;
         $display("FAIL watchdog: actual=timeout expected=completion");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

   initial begin
      void'($urandom(32'd1234));
      model_reset();
      rst = 1'b1;
      repeat (3) @(posedge clk);
      @(negedge clk); rst = 1'b0;
      // R1: everything zero, flags low
      for (int i = 0; i < 16; i++) idle_read("R1", i, 15 - i);

      // R3: write all logical registers of window 0
      for (int i = 0; i < 16; i++) step("R3", 1, i, 32'h1000 + i, 0, 0, 0, i, 0);
      // R2: both ports, distinct indices
      for (int i = 0; i < 16; i++) idle_read("R2", i, (i * 7) % 16);
      // R3: same-cycle write and read return the old value
      step("R3", 1, 5, 32'hAAAA_0005, 0, 0, 0, 5, 5);
      idle_read("R3", 5, 4);

      // R8: rotate by 4 with a write to logical 0: lands in physical 0
      step("R8", 1, 0, 32'hBEEF_0000, 1, 1, 0, 0, 4);
      // R4: caller's r4 now logical 0, r15 now logical 11, logical 12 is fresh
      idle_read("R4", 0, 11);
      idle_read("R4", 12, 15);
      // R4: code 0 changes nothing
      step("R4", 0, 0, '0, 1, 0, 0, 0, 12);
      idle_read("R4", 0, 1);
      // write in the called window, then nest a rotate by 12
      step("R5", 1, 12, 32'hCA11_000C, 1, 3, 0, 12, 0);
      idle_read("R5", 0, 3);
      // R5: restores in LIFO order
      step("R5", 0, 0, '0, 0, 0, 1, 0, 0);
      idle_read("R5", 12, 0);
      step("R5", 0, 0, '0, 0, 0, 1, 0, 4);
      idle_read("R8", 0, 5);

      // R7: restore with empty history
      step("R7", 0, 0, '0, 0, 0, 1, 0, 1);
      idle_read("R7", 0, 15);

      // R9: rotate and restore together; rotate wins
      step("R9", 0, 0, '0, 1, 2, 1, 0, 8);
      idle_read("R9", 0, 7);
      step("R9", 0, 0, '0, 0, 0, 1, 0, 0);

      // R6: group limit: 3,3,3,3 then 1 needs 17 groups of 16
      for (int i = 0; i < 4; i++) step("R6", 0, 0, '0, 1, 3, 0, i, 15);
      step("R6", 0, 0, '0, 1, 1, 0, 0, 1);
      idle_read("R6", 0, 15);
      for (int i = 0; i < 4; i++) step("R6", 0, 0, '0, 0, 0, 1, 0, 4);
      // R6: depth limit: eight rotates by 4, ninth refused
      for (int i = 0; i < 8; i++) step("R6", 0, 0, '0, 1, 1, 0, 0, 2);
      step("R6", 0, 0, '0, 1, 1, 0, 3, 6);
      idle_read("R6", 0, 9);
      for (int i = 0; i < 8; i++) step("R6", 0, 0, '0, 0, 0, 1, 1, 7);

      // random mix
      for (int n = 0; n < 1500; n++) begin
         int r = $urandom_range(0, 99);
         bit re = (r < 18);
         bit rt = (r >= 14 && r < 34);
         step("R2", $urandom_range(0, 1), $urandom_range(0, 15), $urandom,
              re, $urandom_range(0, 3), rt,
              $urandom_range(0, 15), $urandom_range(0, 15));
      end

      // reset mid-run returns everything to zero
      @(negedge clk); rst = 1'b1;
      @(posedge clk); model_reset();
      @(negedge clk); rst = 1'b0;
      for (int i = 0; i < 16; i++) idle_read("R1", i, 15 - i);

      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule